// File: doc/BRIEF.md
# Reloadable timer channel counter

This block is the counting core of one channel of a general-purpose timer. An up-counter advances by one on every enabled clock, starting from zero, until it equals a programmable reload value. In continuous mode it then returns to zero and starts over. In one-shot mode it stops at the reload value and stays there. A pulse marks every wrap and every one-shot finish. Two compare values switch a compare output while the counter runs. The output goes back to a programmable initial level at each wrap.

Software can force the counter in three ways: clear it, load an arbitrary update value, or resynchronise it to the reload value. Resynchronisation can come from an external sync pin on a selectable edge, from this channel's bit of a shared software trigger word, or from the preceding channel's sync-out pulse. This block raises its own sync-out pulse for the next channel in the chain. A debug-halt input freezes the counter when the pause option is set. The register fields arrive as plain input ports.

Top module: `rtmr_chan`

## Requirements
- R1: While `rst` is high and after it is released, `cnt_q` is 0 and `cmp_out`, `rld_pulse`, `cmp0_pulse`, `cmp1_pulse` and `sync_out` are 0.
- R2: Continuous mode (`one_shot`=0): each rising edge with `cnt_en`=1 adds one to `cnt_q`. On the edge where `cnt_q` equals `reload_val`, the counter becomes 0 instead, and `rld_pulse` is 1 for the cycle in which `cnt_q` reads that 0. The period is `reload_val`+1 cycles, and a reload value of 0 gives a pulse on every cycle.
- R3: One-shot mode (`one_shot`=1): the counter climbs to `reload_val` and holds there. `rld_pulse` is 1 for exactly one cycle, starting one edge after the counter reaches `reload_val`. The counter stays stopped until it is cleared, loaded or synchronised.
- R4: While `cnt_clr` is 1, `cnt_q` is 0 after every edge.
- R5: A rising edge of `upd_wr` loads `upd_val` into the counter on that clock edge. Holding `upd_wr` high causes no further loads, so counting resumes from the loaded value.
- R6: An edge on `sync_in` loads `reload_val` into the counter on the (SYNC_STAGES+1)-th clock edge after `sync_in` changes (3 by default). A rising edge counts only when `sync_rise_en`=1 and a falling edge counts only when `sync_fall_en`=1. An edge of a disabled polarity leaves the counter unchanged.
- R7: With `sw_sync_en`=1, a 1 in bit CHAN_IDX of `sw_trig` loads `reload_val` on the next edge. Other bits of `sw_trig` have no effect, and neither does any bit when `sw_sync_en`=0.
- R8: With `follow_en`=1 and CHAN_IDX not 0, a 1 on `prev_sync` loads `reload_val` on the next edge. With `follow_en`=0 it has no effect.
- R9: `sync_out` is 1 for exactly the cycles in which `cnt_q` reads a value that a sync (R6, R7 or R8) has just loaded. It is never 1 in the same cycle as `rld_pulse`.
- R10: When `dbg_pause_en`=1 and `dbg_halt`=1, the counter holds its value. `dbg_halt` alone has no effect.
- R11: While `cmp_en`=0, `cmp_out` equals `cmp_init` one edge later. While `cmp_en`=1, `cmp_out` inverts on each increment that makes `cnt_q` equal `cmp0_val`, and again on each increment that makes it equal `cmp1_val`; in continuous mode it therefore equals `cmp_init` XOR (`cmp0_val` <= `cnt_q` < `cmp1_val`). `cmp0_pulse` and `cmp1_pulse` mark those increments for one cycle. A clear, load, sync, wrap or finish restores `cmp_init`.
- R12: Priority when several actions meet at one edge: clear over update load, update load over sync, and sync over pause or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| one_shot | input | 1 | 1 = stop at reload value, 0 = wrap |
| cnt_clr | input | 1 | Clears and holds the counter at 0 |
| upd_wr | input | 1 | Update strobe, acts on its rising edge |
| upd_val | input | CNT_W | Value loaded by the update strobe |
| reload_val | input | CNT_W | Top count and sync load value |
| cmp0_val | input | CNT_W | First compare value |
| cmp1_val | input | CNT_W | Second compare value |
| cmp_en | input | 1 | Compare output enable |
| cmp_init | input | 1 | Compare output initial level |
| sync_in | input | 1 | External sync pin, asynchronous |
| sync_rise_en | input | 1 | Rising edges of sync_in are valid |
| sync_fall_en | input | 1 | Falling edges of sync_in are valid |
| sw_sync_en | input | 1 | Accept the software trigger |
| sw_trig | input | TRIG_W | Shared software sync trigger word |
| follow_en | input | 1 | Follow the previous channel's sync |
| prev_sync | input | 1 | Sync-out pulse of the previous channel |
| dbg_pause_en | input | 1 | Pause counting while debug halt |
| dbg_halt | input | 1 | Chip is halted in debug |
| cnt_q | output | CNT_W | Counter value |
| cmp_out | output | 1 | Compare output |
| rld_pulse | output | 1 | Wrap or one-shot finish pulse |
| cmp0_pulse | output | 1 | Compare 0 match pulse |
| cmp1_pulse | output | 1 | Compare 1 match pulse |
| sync_out | output | 1 | Sync pulse for the next channel |

## Verification
The main counting path is swept over every reload value from 0 to 7, with every ordered pair of compare values up to one past the top and with both initial levels. Each run lasts two full periods, so wrap timing, off-by-one compare windows and a compare value that is never reached each give a different counter or output trace. Each sync source is tried with the counter idle and preset to a marker value, so a load is clearly separate from the marker. The four polarity-enable combinations tell a taken edge from an ignored one. Held and overlapping strobes against clear, update and sync separate the priority order and the single-load behaviour of the update strobe.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  // What the counter does on the coming clock edge.
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_ZERO,
    SRC_LOAD,
    SRC_RELOAD,
    SRC_INC,
    SRC_WRAP,
    SRC_FINISH
  } cnt_src_e;
endpackage

// File: rtl/rtmr_sync.sv
module rtmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic rise_en,
  input  logic fall_en,
  output logic evt
);
  logic [STAGES-1:0] stg;
  logic              last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= sync_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= stg[STAGES-1];
  end

  assign evt = (rise_en & stg[STAGES-1] & ~last) |
               (fall_en & ~stg[STAGES-1] & last);
endmodule

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
  import rtmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TRIG_W   = 4,
  parameter int CHAN_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              one_shot,
  input  logic              cnt_clr,
  input  logic              upd_wr,
  input  logic              hw_evt,
  input  logic              sw_sync_en,
  input  logic [TRIG_W-1:0] sw_trig,
  input  logic              follow_en,
  input  logic              prev_sync,
  input  logic              dbg_pause_en,
  input  logic              dbg_halt,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  reload_val,
  output cnt_src_e          src
);
  localparam logic [TRIG_W-1:0] MY_TRIG = TRIG_W'(1) << CHAN_IDX;

  logic upd_prev;
  logic done;
  logic follow_hit;
  logic sw_hit;
  logic sync_hit;
  logic upd_edge;
  logic paused;
  logic at_top;

  if (CHAN_IDX != 0) begin : g_follow
    assign follow_hit = follow_en & prev_sync;
  end else begin : g_no_follow
    assign follow_hit = 1'b0;
  end

  assign sw_hit   = sw_sync_en & (|(sw_trig & MY_TRIG));
  assign sync_hit = hw_evt | sw_hit | follow_hit;
  assign upd_edge = upd_wr & ~upd_prev;
  assign paused   = dbg_pause_en & dbg_halt;
  assign at_top   = (cnt_q == reload_val);

  always_comb begin
    if (cnt_clr)                         src = SRC_ZERO;
    else if (upd_edge)                   src = SRC_LOAD;
    else if (sync_hit)                   src = SRC_RELOAD;
    else if (paused || !cnt_en || done)  src = SRC_HOLD;
    else if (at_top)                     src = one_shot ? SRC_FINISH : SRC_WRAP;
    else                                 src = SRC_INC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_prev <= 1'b0;
      done     <= 1'b0;
    end else begin
      upd_prev <= upd_wr;
      case (src)
        SRC_FINISH:                    done <= 1'b1;
        SRC_ZERO, SRC_LOAD, SRC_RELOAD: done <= 1'b0;
        default:                       done <= done;
      endcase
    end
  end
endmodule

// File: rtl/rtmr_core.sv
module rtmr_core
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_src_e         src,
  input  logic [CNT_W-1:0] upd_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             rld_pulse,
  output logic             sync_out
);
  always_comb begin
    case (src)
      SRC_ZERO, SRC_WRAP: cnt_d = '0;
      SRC_LOAD:           cnt_d = upd_val;
      SRC_RELOAD:         cnt_d = reload_val;
      SRC_INC:            cnt_d = cnt_q + CNT_W'(1);
      default:            cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rld_pulse <= 1'b0;
      sync_out  <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rld_pulse <= (src == SRC_WRAP) || (src == SRC_FINISH);
      sync_out  <= (src == SRC_RELOAD);
    end
  end
endmodule

// File: rtl/rtmr_cmp.sv
module rtmr_cmp
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_en,
  input  logic             cmp_init,
  input  cnt_src_e         src,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] cmp0_val,
  input  logic [CNT_W-1:0] cmp1_val,
  output logic             cmp_out,
  output logic             cmp0_pulse,
  output logic             cmp1_pulse
);
  logic hit0;
  logic hit1;

  assign hit0 = (src == SRC_INC) && (cnt_d == cmp0_val);
  assign hit1 = (src == SRC_INC) && (cnt_d == cmp1_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_out    <= 1'b0;
      cmp0_pulse <= 1'b0;
      cmp1_pulse <= 1'b0;
    end else begin
      cmp0_pulse <= hit0;
      cmp1_pulse <= hit1;
      if (!cmp_en) begin
        cmp_out <= cmp_init;
      end else begin
        case (src)
          SRC_HOLD: cmp_out <= cmp_out;
          SRC_INC:  cmp_out <= cmp_out ^ hit0 ^ hit1;
          default:  cmp_out <= cmp_init;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtmr_chan.sv
module rtmr_chan
  import rtmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int TRIG_W      = 4,
  parameter int CHAN_IDX    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              one_shot,
  input  logic              cnt_clr,
  input  logic              upd_wr,
  input  logic [CNT_W-1:0]  upd_val,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic [CNT_W-1:0]  cmp0_val,
  input  logic [CNT_W-1:0]  cmp1_val,
  input  logic              cmp_en,
  input  logic              cmp_init,
  input  logic              sync_in,
  input  logic              sync_rise_en,
  input  logic              sync_fall_en,
  input  logic              sw_sync_en,
  input  logic [TRIG_W-1:0] sw_trig,
  input  logic              follow_en,
  input  logic              prev_sync,
  input  logic              dbg_pause_en,
  input  logic              dbg_halt,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cmp_out,
  output logic              rld_pulse,
  output logic              cmp0_pulse,
  output logic              cmp1_pulse,
  output logic              sync_out
);
  logic             hw_evt;
  cnt_src_e         src;
  logic [CNT_W-1:0] cnt_d;

  rtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sync_in (sync_in),
    .rise_en (sync_rise_en),
    .fall_en (sync_fall_en),
    .evt     (hw_evt)
  );

  rtmr_ctrl #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .CHAN_IDX(CHAN_IDX)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cnt_en       (cnt_en),
    .one_shot     (one_shot),
    .cnt_clr      (cnt_clr),
    .upd_wr       (upd_wr),
    .hw_evt       (hw_evt),
    .sw_sync_en   (sw_sync_en),
    .sw_trig      (sw_trig),
    .follow_en    (follow_en),
    .prev_sync    (prev_sync),
    .dbg_pause_en (dbg_pause_en),
    .dbg_halt     (dbg_halt),
    .cnt_q        (cnt_q),
    .reload_val   (reload_val),
    .src          (src)
  );

  rtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .src        (src),
    .upd_val    (upd_val),
    .reload_val (reload_val),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d),
    .rld_pulse  (rld_pulse),
    .sync_out   (sync_out)
  );

  rtmr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .cmp_en     (cmp_en),
    .cmp_init   (cmp_init),
    .src        (src),
    .cnt_d      (cnt_d),
    .cmp0_val   (cmp0_val),
    .cmp1_val   (cmp1_val),
    .cmp_out    (cmp_out),
    .cmp0_pulse (cmp0_pulse),
    .cmp1_pulse (cmp1_pulse)
  );
endmodule

// File: rtl/rtmr_chk.sv
module rtmr_chk
  import rtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             one_shot,
  input logic             cmp_en,
  input logic             cmp_init,
  input logic [CNT_W-1:0] reload_val,
  input cnt_src_e         src,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rld_pulse,
  input logic             sync_out,
  input logic             cmp_out
);
  assert_clr_zero_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cnt_q == '0);

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rld_pulse && !$past(one_shot)) |-> cnt_q == '0);

  assert_oneshot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rld_pulse && $past(one_shot)) |-> cnt_q == $past(cnt_q));

  assert_sync_load_R9: assert property (@(posedge clk) disable iff (rst)
    sync_out |-> cnt_q == $past(reload_val));

  assert_sync_not_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    !(sync_out && rld_pulse));

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_HOLD) |=> $stable(cnt_q));

  assert_cmp_off_R11: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> cmp_out == $past(cmp_init));
endmodule

bind rtmr_chan rtmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_clr    (cnt_clr),
  .one_shot   (one_shot),
  .cmp_en     (cmp_en),
  .cmp_init   (cmp_init),
  .reload_val (reload_val),
  .src        (src),
  .cnt_q      (cnt_q),
  .rld_pulse  (rld_pulse),
  .sync_out   (sync_out),
  .cmp_out    (cmp_out)
);

// File: tb/sim_rtmr_chan.sv
module sim_rtmr_chan;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int TW         = 4;
  localparam int MARK       = 7;
  localparam int RLD_S      = 120;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_en = 0, one_shot = 0, cnt_clr = 0, upd_wr = 0;
  logic [W-1:0]  upd_val = 0, reload_val = 0, cmp0_val = 0, cmp1_val = 0;
  logic          cmp_en = 0, cmp_init = 0;
  logic          sync_in = 0, sync_rise_en = 0, sync_fall_en = 0;
  logic          sw_sync_en = 0;
  logic [TW-1:0] sw_trig = 0;
  logic          follow_en = 0, prev_sync = 0, dbg_pause_en = 0, dbg_halt = 0;
  logic [W-1:0]  cnt_q;
  logic          cmp_out, rld_pulse, cmp0_pulse, cmp1_pulse, sync_out;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtmr_chan #(.CNT_W(W), .TRIG_W(TW), .CHAN_IDX(1), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .one_shot(one_shot),
    .cnt_clr(cnt_clr), .upd_wr(upd_wr), .upd_val(upd_val),
    .reload_val(reload_val), .cmp0_val(cmp0_val), .cmp1_val(cmp1_val),
    .cmp_en(cmp_en), .cmp_init(cmp_init), .sync_in(sync_in),
    .sync_rise_en(sync_rise_en), .sync_fall_en(sync_fall_en),
    .sw_sync_en(sw_sync_en), .sw_trig(sw_trig), .follow_en(follow_en),
    .prev_sync(prev_sync), .dbg_pause_en(dbg_pause_en), .dbg_halt(dbg_halt),
    .cnt_q(cnt_q), .cmp_out(cmp_out), .rld_pulse(rld_pulse),
    .cmp0_pulse(cmp0_pulse), .cmp1_pulse(cmp1_pulse), .sync_out(sync_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic preset(input int v);
    upd_val = W'(v);
    upd_wr  = 1'b1;
    tick();
    upd_wr  = 1'b0;
    tick();
  endtask

  task automatic clear_cnt();
    cnt_en  = 1'b0;
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
  endtask

  task automatic sweep(input int r, input int c0, input int c1, input bit ini);
    int c;
    one_shot   = 1'b0;
    reload_val = W'(r);
    cmp0_val   = W'(c0);
    cmp1_val   = W'(c1);
    cmp_en     = 1'b1;
    cmp_init   = ini;
    clear_cnt();
    chk("R4 clear before sweep", int'(cnt_q), 0);
    chk("R11 level after clear", int'(cmp_out), int'(ini));
    cnt_en = 1'b1;
    for (int k = 1; k <= 2 * (r + 1) + 1; k++) begin
      tick();
      c = k % (r + 1);
      chk("R2 count", int'(cnt_q), c);
      chk("R2 reload pulse", int'(rld_pulse), (c == 0) ? 1 : 0);
      chk("R11 compare level", int'(cmp_out),
          int'(ini) ^ ((c >= c0 && c < c1) ? 1 : 0));
      chk("R11 compare0 pulse", int'(cmp0_pulse), (c == c0) ? 1 : 0);
      chk("R11 compare1 pulse", int'(cmp1_pulse), (c == c1) ? 1 : 0);
    end
    cnt_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    tick();
    chk("R1 count in reset", int'(cnt_q), 0);
    repeat (2) tick();
    rst = 1'b0;
    tick();
    chk("R1 count after reset", int'(cnt_q), 0);
    chk("R1 compare out", int'(cmp_out), 0);
    chk("R1 reload pulse", int'(rld_pulse), 0);
    chk("R1 sync out", int'(sync_out), 0);
    chk("R1 compare pulses", int'(cmp0_pulse) + int'(cmp1_pulse), 0);

    // R11: disabled compare follows the initial level
    cmp_en = 1'b0; cmp_init = 1'b1; tick();
    chk("R11 disabled high", int'(cmp_out), 1);
    cmp_init = 1'b0; tick();
    chk("R11 disabled low", int'(cmp_out), 0);

    // R2 and R11 sweeps over a small configuration
    for (int r = 0; r <= 7; r++)
      for (int c0 = 1; c0 <= r + 1; c0++)
        for (int c1 = c0 + 1; c1 <= r + 2; c1++)
          sweep(r, c0, c1, bit'((r + c0) % 2));
    cmp_en = 1'b0;

    // R3 one-shot
    one_shot = 1'b1; reload_val = 4;
    clear_cnt();
    cnt_en = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      tick();
      chk("R3 one-shot count", int'(cnt_q), (k < 4) ? k : 4);
      chk("R3 one-shot pulse", int'(rld_pulse), (k == 5) ? 1 : 0);
    end
    one_shot = 1'b0;

    // R5 update load while running, strobe held
    reload_val = 200;
    clear_cnt();
    cnt_en = 1'b1;
    repeat (3) tick();
    upd_val = 50; upd_wr = 1'b1;
    tick(); chk("R5 update load", int'(cnt_q), 50);
    tick(); chk("R5 held strobe no reload", int'(cnt_q), 51);
    tick(); chk("R5 held strobe no reload", int'(cnt_q), 52);
    upd_wr = 1'b0;
    tick(); chk("R5 count after strobe", int'(cnt_q), 53);

    // R10 debug pause
    dbg_pause_en = 1'b1; dbg_halt = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(); chk("R10 paused", int'(cnt_q), 53);
    end
    dbg_halt = 1'b0;
    tick(); chk("R10 resume", int'(cnt_q), 54);
    dbg_pause_en = 1'b0; dbg_halt = 1'b1;
    tick(); chk("R10 halt without pause", int'(cnt_q), 55);
    dbg_halt = 1'b0;

    // R12 clear beats update, strobe edge consumed; R4 clear held
    upd_val = 90; upd_wr = 1'b1; cnt_clr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick(); chk("R12 R4 clear wins", int'(cnt_q), 0);
    end
    cnt_clr = 1'b0;
    tick(); chk("R5 no late load", int'(cnt_q), 1);
    upd_wr = 1'b0;
    tick(); chk("R2 counting on", int'(cnt_q), 2);
    cnt_en = 1'b0;
    tick();

    // R7 software sync
    reload_val = RLD_S;
    preset(MARK);
    sw_sync_en = 1'b1; sw_trig = 4'b0010;
    tick();
    chk("R7 own trigger bit", int'(cnt_q), RLD_S);
    chk("R9 sync out set", int'(sync_out), 1);
    sw_trig = 4'b0000;
    tick();
    chk("R9 sync out one cycle", int'(sync_out), 0);
    preset(MARK);
    sw_trig = 4'b1101;
    tick();
    chk("R7 other bits ignored", int'(cnt_q), MARK);
    chk("R9 no sync out", int'(sync_out), 0);
    sw_trig = 4'b0000;
    sw_sync_en = 1'b0;
    sw_trig = 4'b0010;
    tick();
    chk("R7 disabled ignored", int'(cnt_q), MARK);
    sw_trig = 4'b0000;

    // R12 update beats sync, sync beats pause
    sw_sync_en = 1'b1;
    tick();
    upd_val = 33; upd_wr = 1'b1; sw_trig = 4'b0010;
    tick();
    chk("R12 update over sync", int'(cnt_q), 33);
    chk("R12 no sync out", int'(sync_out), 0);
    upd_wr = 1'b0; sw_trig = 4'b0000;
    tick();
    dbg_pause_en = 1'b1; dbg_halt = 1'b1; sw_trig = 4'b0010;
    tick();
    chk("R12 sync over pause", int'(cnt_q), RLD_S);
    sw_trig = 4'b0000; dbg_pause_en = 1'b0; dbg_halt = 1'b0;
    sw_sync_en = 1'b0;

    // R8 follow sync
    follow_en = 1'b1;
    preset(MARK);
    prev_sync = 1'b1; tick(); prev_sync = 1'b0;
    chk("R8 follow load", int'(cnt_q), RLD_S);
    chk("R9 follow sync out", int'(sync_out), 1);
    follow_en = 1'b0;
    preset(MARK);
    prev_sync = 1'b1; tick(); prev_sync = 1'b0;
    chk("R8 follow disabled", int'(cnt_q), MARK);

    // R6 external sync, all polarity-enable combinations
    for (int m = 0; m < 4; m++) begin
      sync_rise_en = m[0];
      sync_fall_en = m[1];
      preset(MARK);
      sync_in = 1'b1;
      tick(); tick();
      chk("R6 rise not yet", int'(cnt_q), MARK);
      tick();
      chk("R6 rising edge", int'(cnt_q), m[0] ? RLD_S : MARK);
      chk("R9 rising sync out", int'(sync_out), m[0] ? 1 : 0);
      preset(MARK);
      sync_in = 1'b0;
      tick(); tick(); tick();
      chk("R6 falling edge", int'(cnt_q), m[1] ? RLD_S : MARK);
      chk("R9 falling sync out", int'(sync_out), m[1] ? 1 : 0);
    end

    finish_run();
  end
endmodule